// File: doc/BRIEF.md
# Residual angle recoding unit

This unit is the angle-side step of a word-serial CORDIC rotator. Each time a residual rotation angle is presented, it finds the leading one of the residue's magnitude and reads the four bits that start there. From those four bits and the leading-one position, it picks two micro-rotation indices (s, t) that are applied together in one iteration. It then returns the rotation direction and the residue that remains after subtracting the two matching arctangent values. Both micro-rotations always turn the same way, so only the two indices leave the block, together with one direction bit.

The residue is a signed two's-complement word with one integer bit and eleven fraction bits, so one unit is 2^-11 rad. Arctangent values come from a small stored table for indices 0 to 4. Higher indices are made by halving the index-4 word once per step, and they reach zero past the word length. A new residue is accepted on any cycle with the valid strobe set, and the results appear, registered, on the next cycle.

Top module: `angle_recoder`

## Requirements
- R1: While rst_n is low, out_valid, s_idx, t_idx, rot_cw, next_residue and is_zero are all 0.
- R2: out_valid equals in_valid of the previous cycle. On a cycle with in_valid low, the other outputs keep their values.
- R3: A residue of 0 gives is_zero = 1, s_idx = t_idx = 0, rot_cw = 0 and next_residue = 0. Any other residue gives is_zero = 0.
- R4: rot_cw is 1 (clockwise) exactly when the residue is negative (sign bit 11 set). All lookups use the magnitude |z|.
- R5: If b is the bit position of the highest set bit of |z|, then k = 11 - b. The key is bits b down to b-3 of |z|, and any position below bit 0 reads as 0, so the key always has a 1 in its top bit.
- R6: For k <= 1, s = k in every case. The key decides t: 1000 gives t = k+3, 1001 and 1010 give t = k+2, and 1011 and 1100 give t = k+1. The keys 1101, 1110 and 1111 lie outside the 0..pi/4 range and are treated like 1100.
- R7: For k > 1, keys 1000, 1001 and 1010 give (k, k+4), (k, k+3) and (k, k+2). Keys 1011, 1100 and 1101 give (k, k+1). Key 1110 gives (k-1, k+5) and key 1111 gives (k-1, k+3).
- R8: The angle for index m is 1608, 950, 502, 255 and 128 for m = 0..4. For m >= 5 it is 128 shifted right by (m-4), which is 0 for m >= 12.
- R9: next_residue = z - (A(s)+A(t)) for a positive residue and z + (A(s)+A(t)) for a negative one, where A is the angle of R8. The magnitude of next_residue never exceeds |z|.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Residue strobe |
| residue | input | 12 | Signed residual angle, 1.11 format |
| out_valid | output | 1 | Results valid |
| s_idx | output | 5 | First micro-rotation index |
| t_idx | output | 5 | Second micro-rotation index |
| rot_cw | output | 1 | 1 = clockwise (negative residue) |
| next_residue | output | 12 | Residue after the combined rotation |
| is_zero | output | 1 | Residue was zero; no lookup done |

## Verification
The assertions assume the residue stays within plus or minus pi/4, which is 1608 codes. Inside that range the index order and the shrinking residue can be guaranteed, and the most negative code, whose magnitude cannot be represented, never appears. The stimulus sweeps every residue from -1608 to +1608 and then draws random values that are folded into the same range. Directed cases cover zero, the range ends, single-bit values and keys near the padded LSB.

// File: rtl/angle_recoder.sv
module angle_recoder #(
  parameter int W  = 12,
  parameter int IW = $clog2(W + 6)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  residue,
  output logic          out_valid,
  output logic [IW-1:0] s_idx,
  output logic [IW-1:0] t_idx,
  output logic          rot_cw,
  output logic [W-1:0]  next_residue,
  output logic          is_zero
);
  localparam int FRAC = W - 1;

  logic [W-1:0]  mag;
  logic [IW-1:0] lead, k, s_n, t_n;
  logic [W+2:0]  win;
  logic [3:0]    key;
  logic [W:0]    sum;
  logic [W-1:0]  nxt;

  assign mag = residue[W-1] ? (~residue + 1'b1) : residue;

  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++)
      if (mag[i]) lead = IW'(i);
  end

  assign k   = IW'(FRAC) - lead;
  assign win = {mag, 3'b000} >> lead;
  assign key = win[3:0];

  always_comb begin
    s_n = k;
    t_n = k + IW'(1);
    if (k <= IW'(1)) begin
      case (key)
        4'b1000:         t_n = k + IW'(3);
        4'b1001, 4'b1010: t_n = k + IW'(2);
        default:         t_n = k + IW'(1);
      endcase
    end else begin
      case (key)
        4'b1000: t_n = k + IW'(4);
        4'b1001: t_n = k + IW'(3);
        4'b1010: t_n = k + IW'(2);
        4'b1110: begin s_n = k - IW'(1); t_n = k + IW'(5); end
        4'b1111: begin s_n = k - IW'(1); t_n = k + IW'(3); end
        default: t_n = k + IW'(1);
      endcase
    end
  end

  function automatic logic [W-1:0] atan_w(input logic [IW-1:0] m);
    case (m)
      IW'(0):  atan_w = W'(1608);
      IW'(1):  atan_w = W'(950);
      IW'(2):  atan_w = W'(502);
      IW'(3):  atan_w = W'(255);
      IW'(4):  atan_w = W'(128);
      default: atan_w = W'(128) >> (m - IW'(4));
    endcase
  endfunction

  assign sum = {1'b0, atan_w(s_n)} + {1'b0, atan_w(t_n)};
  assign nxt = residue[W-1] ? residue + sum[W-1:0] : residue - sum[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      s_idx        <= '0;
      t_idx        <= '0;
      rot_cw       <= 1'b0;
      next_residue <= '0;
      is_zero      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (mag == '0) begin
          s_idx        <= '0;
          t_idx        <= '0;
          rot_cw       <= 1'b0;
          next_residue <= '0;
          is_zero      <= 1'b1;
        end else begin
          s_idx        <= s_n;
          t_idx        <= t_n;
          rot_cw       <= residue[W-1];
          next_residue <= nxt;
          is_zero      <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/angle_recoder_chk.sv
module angle_recoder_chk #(
  parameter int W  = 12,
  parameter int IW = $clog2(W + 6)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  residue,
  input logic          out_valid,
  input logic [IW-1:0] s_idx,
  input logic [IW-1:0] t_idx,
  input logic          rot_cw,
  input logic [W-1:0]  next_residue,
  input logic          is_zero
);
  logic [W-1:0] mag_in, mag_out;
  assign mag_in  = residue[W-1] ? (~residue + 1'b1) : residue;
  assign mag_out = next_residue[W-1] ? (~next_residue + 1'b1) : next_residue;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && next_residue == '0 && !is_zero));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_residue) && $stable(s_idx) && $stable(t_idx)));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (is_zero == ($past(residue) == '0)));

  a_r4_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && residue != '0) |=> (rot_cw == $past(residue[W-1])));

  a_r7_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_zero) |-> (t_idx > s_idx));

  a_r9_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && residue != '0) |=> (mag_out <= $past(mag_in)));
endmodule

bind angle_recoder angle_recoder_chk #(.W(W), .IW(IW)) i_chk (.*);

// File: tb/test_angle_recoder.sv
module test_angle_recoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] residue = '0;
  logic        out_valid;
  logic [4:0]  s_idx, t_idx;
  logic        rot_cw;
  logic [11:0] next_residue;
  logic        is_zero;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  angle_recoder i_angle_recoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .residue(residue),
    .out_valid(out_valid), .s_idx(s_idx), .t_idx(t_idx), .rot_cw(rot_cw),
    .next_residue(next_residue), .is_zero(is_zero)
  );

  function automatic int ref_angle(int m);
    case (m)
      0: return 1608;
      1: return 950;
      2: return 502;
      3: return 255;
      4: return 128;
      default: return (m >= 12) ? 0 : (128 >> (m - 4));
    endcase
  endfunction

  function automatic void ref_model(int z, output int s, output int t, output int cw,
                                    output int nz, output int zf);
    int mg, b, k, key;
    if (z == 0) begin s = 0; t = 0; cw = 0; nz = 0; zf = 1; return; end
    zf = 0;
    cw = (z < 0);
    mg = (z < 0) ? -z : z;
    b = 0;
    for (int i = 0; i < 12; i++) if ((mg >> i) & 1) b = i;
    k = 11 - b;
    key = ((mg << 3) >> b) & 15;
    s = k;
    if (k <= 1) begin
      case (key)
        8: t = k + 3;
        9, 10: t = k + 2;
        default: t = k + 1;
      endcase
    end else begin
      case (key)
        8: t = k + 4;
        9: t = k + 3;
        10: t = k + 2;
        14: begin s = k - 1; t = k + 5; end
        15: begin s = k - 1; t = k + 3; end
        default: t = k + 1;
      endcase
    end
    nz = (z < 0) ? z + ref_angle(s) + ref_angle(t) : z - ref_angle(s) - ref_angle(t);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(int z);
    int s, t, cw, nz, zf;
    @(negedge clk);
    in_valid = 1'b1;
    residue  = 12'(z);
    ref_model(z, s, t, cw, nz, zf);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "out_valid", int'(out_valid), 1);
    check("R3", "is_zero", int'(is_zero), zf);
    check("R4", "rot_cw", int'(rot_cw), cw);
    check("R6/R7 s", "s_idx", int'(s_idx), s);
    check("R6/R7 t", "t_idx", int'(t_idx), t);
    check("R9", "next_residue", int'($signed(next_residue)), nz);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "next_residue", int'(next_residue), 0);
    check("R1", "s_idx", int'(s_idx), 0);
    check("R1", "is_zero", int'(is_zero), 0);
    rst_n = 1'b1;

    // R3 zero, R5 padded keys near LSB, R8 tail angles
    apply(0);
    apply(1); apply(2); apply(3); apply(7);
    apply(-1); apply(-5);
    // R6 top of range and k=1 keys
    apply(1608); apply(-1608); apply(1024); apply(1152); apply(1280); apply(1408); apply(1536);
    // R7 k>1 keys 1110 and 1111
    apply(896); apply(960); apply(-1000);
    for (int b = 0; b < 11; b++) apply(1 << b);

    // R2 hold: in_valid low changes nothing
    apply(777);
    begin
      int s, t, cw, nz, zf;
      ref_model(777, s, t, cw, nz, zf);
      @(negedge clk);
      residue = 12'(-300);
      @(negedge clk);
      check("R2", "out_valid low", int'(out_valid), 0);
      check("R2", "held next_residue", int'($signed(next_residue)), nz);
      check("R2", "held t_idx", int'(t_idx), t);
    end

    // R5..R9 full sweep
    for (int z = -1608; z <= 1608; z++) apply(z);

    // random
    void'($urandom(32'd4711));
    for (int i = 0; i < 2000; i++) apply(int'($urandom % 3217) - 1608);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule